// File: doc/BRIEF.md
# Receiver Reset Sequencing Controller

This block takes a serial transceiver receiver out of reset in a safe order after power-up. While the active-high power-on reset input is high, it drives a management reset that starts calibration, and it holds both the analog and the digital receiver resets. Once power-on reset drops, the management pulse ends after a parameterised number of cycles. The analog reset is then released a fixed delay after calibration stops reporting busy. The digital reset is released only after the clock-data-recovery lock-to-data status has stayed high, without a break, for a qualification window. If lock falls before that window is complete, the window starts again from zero.

Both status inputs are asynchronous and each goes through a two-flop synchronizer. All delays are counted in cycles of the single free-running clock, so parameters set the real-time minimums. After bring-up, a loss of lock puts the receiver back into digital reset and requalifies it, while the analog reset stays released. A new calibration-busy puts both resets back and restarts the whole sequence from the calibration wait. A ready output reports that both resets are released.

Edge counts below are clock rising edges, counted from the first edge after an input change. All parameters must be at least 1, and `MGMT_RST_CYC` must be at least 2.

Top module: `rx_reset_seq`

## Requirements
- R1: `mgmt_rst` is 1 while `por` is 1. It falls exactly `MGMT_RST_CYC`+2 edges after `por` falls, and it never rises again until the next `por`.
- R2: `rx_ana_rst` and `rx_dig_rst` are 1 while `por` is 1. Each stays 1 until its own release condition below is met.
- R3: When the controller is waiting for calibration and `cal_busy_in` falls and stays 0, `rx_ana_rst` falls exactly `CAL_DLY_CYC`+3 edges after that fall.
- R4: If `cal_busy_in` returns to 1 before `rx_ana_rst` is released, the analog reset stays 1. The full `CAL_DLY_CYC` delay is then counted again from the next fall.
- R5: `rx_dig_rst` falls only while `rx_ana_rst` is 0 and calibration is idle. If `cdr_lock_in` is already steadily 1 when the analog reset falls, the digital reset falls exactly `LTD_CYC` edges after the analog reset. If lock rises later, it falls `LTD_CYC`+2 edges after that rise.
- R6: If `cdr_lock_in` falls before qualification completes, there is no release. The full `LTD_CYC` window is counted again from the next rise.
- R7: Changes of `cdr_lock_in` while `rx_ana_rst` is 1 have no effect on any output.
- R8: When `cdr_lock_in` falls while the receiver is running, `rx_dig_rst` rises 3 edges later and `rx_ana_rst` stays 0.
- R9: When `cal_busy_in` rises after the management pulse, `rx_ana_rst` and `rx_dig_rst` both rise 3 edges later, and the sequence restarts at the calibration wait.
- R10: `rx_ready` is 1 exactly when both receiver resets are 0. It changes on the same edge as `rx_dig_rst`.
- R11: No output changes except at the edges named in R1 to R10. There are no glitches and no extra transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por | input | 1 | Power-on reset, active high, asynchronous assert |
| cal_busy_in | input | 1 | Calibration busy status, asynchronous |
| cdr_lock_in | input | 1 | CDR lock-to-data status, asynchronous |
| mgmt_rst | output | 1 | Management reset, starts calibration |
| rx_ana_rst | output | 1 | Analog receiver reset, active high |
| rx_dig_rst | output | 1 | Digital receiver reset, active high |
| rx_ready | output | 1 | Both receiver resets released |

## Verification
The hardest case to reach is a lock drop that lands one cycle before qualification would have completed. If the timer did not reload, the digital reset would be released early. The stimulus raises lock, waits `LTD_CYC`-1 cycles, and drops it for three cycles. The scoreboard expects no transition at the edge where the release would otherwise have fallen, and it expects the release `LTD_CYC`+2 edges after the second rise. A second hard case is a calibration-busy that returns during the post-calibration delay. The stimulus raises busy three cycles into the delay and expects the analog reset to stay asserted. A lock toggle is also driven while the analog reset is held, and the scoreboard treats any resulting output change as a failure.

// File: rtl/rx_reset_seq_pkg.sv
package rx_reset_seq_pkg;
  typedef enum logic [2:0] {
    ST_MGMT     = 3'd0,
    ST_CAL_WAIT = 3'd1,
    ST_ANA_DLY  = 3'd2,
    ST_LTD_QUAL = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rx_reset_seq_sync.sv
// Two-flop synchronizer, one per bit, with a per-bit safe reset value.
module rx_reset_seq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_in;
      sync_q <= meta_q;
    end
  end

  assign q_out = sync_q;
endmodule

// File: rtl/rx_reset_seq_timer.sv
// Down-counter: load wins, otherwise count toward zero and hold there.
module rx_reset_seq_timer #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic         dec_en;

  assign dec_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec_en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rx_reset_seq.sv
module rx_reset_seq
  import rx_reset_seq_pkg::*;
#(
  parameter int unsigned MGMT_RST_CYC = 2,
  parameter int unsigned CAL_DLY_CYC  = 250,
  parameter int unsigned LTD_CYC      = 2500
) (
  input  logic clk,
  input  logic por,
  input  logic cal_busy_in,
  input  logic cdr_lock_in,
  output logic mgmt_rst,
  output logic rx_ana_rst,
  output logic rx_dig_rst,
  output logic rx_ready
);
  localparam int unsigned MAX_A = (MGMT_RST_CYC > CAL_DLY_CYC) ? MGMT_RST_CYC : CAL_DLY_CYC;
  localparam int unsigned MAX_C = (MAX_A > LTD_CYC) ? MAX_A : LTD_CYC;
  localparam int unsigned CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] MGMT_LD = CW'(MGMT_RST_CYC - 1);
  localparam logic [CW-1:0] CAL_LD  = CW'(CAL_DLY_CYC - 1);
  localparam logic [CW-1:0] LTD_LD  = CW'(LTD_CYC - 1);

  // Reset: asserted asynchronously by por, released on the second clock edge.
  logic [1:0] por_q;
  logic       rst_n;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      por_q <= 2'b00;
    end else begin
      por_q <= {por_q[0], 1'b1};
    end
  end

  assign rst_n = por_q[1];

  // Status synchronizers: busy resets to 1 and lock resets to 0, the safe values.
  logic [1:0] stat_s;
  logic       busy_s;
  logic       lock_s;

  rx_reset_seq_sync #(.W(2), .RST_VAL(2'b01)) u_stat_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cdr_lock_in, cal_busy_in}),
    .q_out (stat_s)
  );

  assign busy_s = stat_s[0];
  assign lock_s = stat_s[1];

  // Shared wait timer.
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  rx_reset_seq_timer #(.W(CW), .RST_VAL(MGMT_LD)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // Next-state logic.
  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = LTD_LD;
    unique case (state_q)
      ST_MGMT: begin
        if (tmr_zero) state_d = ST_CAL_WAIT;
      end
      ST_CAL_WAIT: begin
        if (!busy_s) begin
          state_d  = ST_ANA_DLY;
          tmr_load = 1'b1;
          tmr_val  = CAL_LD;
        end
      end
      ST_ANA_DLY: begin
        if (busy_s) begin
          state_d = ST_CAL_WAIT;
        end else if (tmr_zero) begin
          state_d  = ST_LTD_QUAL;
          tmr_load = 1'b1;
        end
      end
      ST_LTD_QUAL: begin
        if (busy_s) begin
          state_d = ST_CAL_WAIT;
        end else if (!lock_s) begin
          tmr_load = 1'b1;
        end else if (tmr_zero) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (busy_s) begin
          state_d = ST_CAL_WAIT;
        end else if (!lock_s) begin
          state_d  = ST_LTD_QUAL;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_MGMT;
    endcase
  end

  // Registered outputs, decoded from the next state so they change cleanly.
  logic mgmt_d;
  logic ana_d;
  logic run_d;

  assign mgmt_d = (state_d == ST_MGMT);
  assign ana_d  = (state_d == ST_MGMT) || (state_d == ST_CAL_WAIT) || (state_d == ST_ANA_DLY);
  assign run_d  = (state_d == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_MGMT;
      mgmt_rst   <= 1'b1;
      rx_ana_rst <= 1'b1;
      rx_dig_rst <= 1'b1;
      rx_ready   <= 1'b0;
    end else begin
      state_q    <= state_d;
      mgmt_rst   <= mgmt_d;
      rx_ana_rst <= ana_d;
      rx_dig_rst <= !run_d;
      rx_ready   <= run_d;
    end
  end
endmodule

// File: rtl/rx_reset_seq_chk.sv
module rx_reset_seq_chk #(
  parameter int unsigned LTD_CYC = 2500
) (
  input logic clk,
  input logic por,
  input logic rst_n,
  input logic busy_s,
  input logic lock_s,
  input logic mgmt_rst,
  input logic rx_ana_rst,
  input logic rx_dig_rst,
  input logic rx_ready
);
  localparam int unsigned RW = $clog2(LTD_CYC + 1);

  // Count of consecutive synchronized lock cycles, saturating at the window.
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!lock_s) begin
      run_q <= '0;
    end else if (run_q != RW'(LTD_CYC)) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_MGMT_WITH_RESETS: assert property (@(posedge clk) disable iff (por || !rst_n) mgmt_rst |-> (rx_ana_rst && rx_dig_rst)); // R1
  AST_MGMT_NO_RETURN: assert property (@(posedge clk) disable iff (por || !rst_n) !mgmt_rst |=> !mgmt_rst); // R1
  AST_DIG_AFTER_ANA: assert property (@(posedge clk) disable iff (por || !rst_n) !rx_dig_rst |-> !rx_ana_rst); // R5
  AST_DIG_REL_LOCKED: assert property (@(posedge clk) disable iff (por || !rst_n) $fell(rx_dig_rst) |-> ($past(lock_s) && !$past(busy_s))); // R5
  AST_LTD_QUALIFIED: assert property (@(posedge clk) disable iff (por || !rst_n) $fell(rx_dig_rst) |-> (run_q == RW'(LTD_CYC))); // R6
  AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (por || !rst_n) !lock_s |=> rx_dig_rst); // R8
  AST_BUSY_RESET: assert property (@(posedge clk) disable iff (por || !rst_n) busy_s |=> (rx_ana_rst && rx_dig_rst)); // R9
  AST_READY_MATCH: assert property (@(posedge clk) disable iff (por || !rst_n) rx_ready == (!rx_ana_rst && !rx_dig_rst)); // R10
endmodule

bind rx_reset_seq rx_reset_seq_chk #(.LTD_CYC(LTD_CYC)) u_chk (
  .clk        (clk),
  .por        (por),
  .rst_n      (rst_n),
  .busy_s     (busy_s),
  .lock_s     (lock_s),
  .mgmt_rst   (mgmt_rst),
  .rx_ana_rst (rx_ana_rst),
  .rx_dig_rst (rx_dig_rst),
  .rx_ready   (rx_ready)
);

// File: tb/rx_reset_seq_bench.sv
module rx_reset_seq_bench;
  localparam int M = 2;
  localparam int D = 5;
  localparam int L = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por, busy, lock;
  logic mgmt_rst, rx_ana_rst, rx_dig_rst, rx_ready;

  rx_reset_seq #(.MGMT_RST_CYC(M), .CAL_DLY_CYC(D), .LTD_CYC(L)) u_rx_reset_seq (
    .clk         (clk),
    .por         (por),
    .cal_busy_in (busy),
    .cdr_lock_in (lock),
    .mgmt_rst    (mgmt_rst),
    .rx_ana_rst  (rx_ana_rst),
    .rx_dig_rst  (rx_dig_rst),
    .rx_ready    (rx_ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Signal index: 0 mgmt_rst, 1 rx_ana_rst, 2 rx_dig_rst, 3 rx_ready.
  typedef struct {
    int    sig;
    logic  val;
    int    at;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t got;

  logic [3:0] cur;
  logic [3:0] prev;
  bit         mon_on = 1'b0;

  assign cur = {rx_ready, rx_dig_rst, rx_ana_rst, mgmt_rst};

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_ev(input int sig, input logic val, input int at, input string tag);
    exp_t e;
    e.sig = sig;
    e.val = val;
    e.at  = at;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every output change must match the next expected item (R11).
  always @(negedge clk) begin
    if (mon_on) begin
      for (int s = 0; s < 4; s++) begin
        if (cur[s] !== prev[s]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 R11", $sformatf("unexpected change sig=%0d cyc=%0d", s, cyc),
                int'(cur[s]), int'(prev[s]));
          end else begin
            got = exp_q.pop_front();
            chk((got.sig == s) && (got.val === cur[s]) && (got.at == cyc), got.tag,
                $sformatf("sig=%0d val=%0b cycle (exp sig=%0d val=%0b)", s, cur[s], got.sig, got.val),
                cyc, got.at);
          end
          prev[s] = cur[s];
        end
      end
    end
  end

  initial begin
    int c;
    int r;
    por  = 1'b1;
    busy = 1'b1;
    lock = 1'b0;
    wait_cyc(3);
    // Reset state
    chk(mgmt_rst === 1'b1, "R1", "mgmt_rst in por", int'(mgmt_rst), 1);
    chk(rx_ana_rst === 1'b1, "R2", "rx_ana_rst in por", int'(rx_ana_rst), 1);
    chk(rx_dig_rst === 1'b1, "R2", "rx_dig_rst in por", int'(rx_dig_rst), 1);
    chk(rx_ready === 1'b0, "R10", "rx_ready in por", int'(rx_ready), 0);
    prev   = cur;
    mon_on = 1'b1;

    // R1: management pulse ends M+2 edges after por release
    c = cyc;
    por = 1'b0;
    expect_ev(0, 1'b0, c + M + 2, "R1");
    wait_cyc(10);

    // R3: analog release; R7: lock toggle while analog held has no effect
    c = cyc;
    busy = 1'b0;
    expect_ev(1, 1'b0, c + D + 3, "R3");
    wait_cyc(1);
    lock = 1'b1;
    wait_cyc(2);
    lock = 1'b0;
    wait_cyc(D + 3);
    // R5: lock rises during qualification, release L+2 edges later
    r = cyc;
    lock = 1'b1;
    expect_ev(2, 1'b0, r + L + 2, "R5");
    expect_ev(3, 1'b1, r + L + 2, "R10");
    wait_cyc(L + 6);
    chk(rx_ready === 1'b1, "R10", "ready after bring-up", int'(rx_ready), 1);

    // R8: lock loss while running, then requalification
    c = cyc;
    lock = 1'b0;
    expect_ev(2, 1'b1, c + 3, "R8");
    expect_ev(3, 1'b0, c + 3, "R10");
    wait_cyc(4);
    chk(rx_ana_rst === 1'b0, "R8", "analog stays released", int'(rx_ana_rst), 0);
    r = cyc;
    lock = 1'b1;
    expect_ev(2, 1'b0, r + L + 2, "R5");
    expect_ev(3, 1'b1, r + L + 2, "R10");
    wait_cyc(L + 6);

    // R6: lock drops one cycle before qualification would complete
    c = cyc;
    lock = 1'b0;
    expect_ev(2, 1'b1, c + 3, "R8");
    expect_ev(3, 1'b0, c + 3, "R10");
    wait_cyc(4);
    lock = 1'b1;
    wait_cyc(L - 1);
    lock = 1'b0;
    wait_cyc(3);
    r = cyc;
    lock = 1'b1;
    expect_ev(2, 1'b0, r + L + 2, "R6");
    expect_ev(3, 1'b1, r + L + 2, "R10");
    wait_cyc(L + 6);

    // R9: calibration busy again while running, full restart with lock steady
    c = cyc;
    busy = 1'b1;
    expect_ev(1, 1'b1, c + 3, "R9");
    expect_ev(2, 1'b1, c + 3, "R9");
    expect_ev(3, 1'b0, c + 3, "R10");
    wait_cyc(5);
    c = cyc;
    busy = 1'b0;
    expect_ev(1, 1'b0, c + D + 3, "R3");
    expect_ev(2, 1'b0, c + D + 3 + L, "R5");
    expect_ev(3, 1'b1, c + D + 3 + L, "R10");
    wait_cyc(D + L + 8);

    // R4: busy returns during the post-calibration delay
    c = cyc;
    busy = 1'b1;
    expect_ev(1, 1'b1, c + 3, "R9");
    expect_ev(2, 1'b1, c + 3, "R9");
    expect_ev(3, 1'b0, c + 3, "R10");
    wait_cyc(5);
    busy = 1'b0;
    wait_cyc(3);
    busy = 1'b1;
    wait_cyc(D + 3);
    chk(rx_ana_rst === 1'b1, "R4", "analog held after busy returned", int'(rx_ana_rst), 1);
    c = cyc;
    busy = 1'b0;
    expect_ev(1, 1'b0, c + D + 3, "R4");
    expect_ev(2, 1'b0, c + D + 3 + L, "R5");
    expect_ev(3, 1'b1, c + D + 3 + L, "R10");
    // R7: lock glitch while analog is still held
    wait_cyc(1);
    lock = 1'b0;
    wait_cyc(1);
    lock = 1'b1;
    wait_cyc(D + L + 8);

    chk(exp_q.size() == 0, "R11", "expected events left", exp_q.size(), 0);
    chk(mgmt_rst === 1'b0, "R1", "mgmt_rst stays low", int'(mgmt_rst), 0);
    chk(rx_ready === 1'b1, "R10", "final ready", int'(rx_ready), 1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule